// File: doc/BRIEF.md
# Serial Character Receiver with Status FIFO

This block recovers asynchronous serial characters from a single input line. It is driven by a one-cycle enable that pulses at sixteen times the bit rate. A falling line starts a character. The receiver confirms the start bit at mid-bit, then samples each data bit, the optional parity bit and the stop bit in the middle of its bit cell. The character length is selectable from five to eight bits. Parity can be off, even, odd or forced to a fixed level.

Each finished character is written into a three-entry FIFO together with three flags: break, framing error and parity error. A fourth character can be assembling in the shift register while the FIFO is full, so up to four characters are held at once. The host sees the oldest entry directly on the read outputs and removes it with a single-cycle pop strobe. The status outputs are ready (FIFO holds data), full, and a sticky overrun flag that a clear input resets.

When a stop bit is sampled low and the character was not all zeros, the entry is flagged as a framing error. If the line is still low half a bit later, that instant is taken as the falling edge of a new start bit. An all-zero character, with a zero parity bit and a zero stop bit, is stored once as a break. No further start is accepted until the line has returned high.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, rx_ready, fifo_full and overrun are 0 and the read outputs rd_data, rd_brk, rd_fe and rd_pe are all 0.
- R2: bits_sel selects the character length: 0, 1, 2 or 3 gives 5, 6, 7 or 8 data bits. Bits arrive least significant first. rd_data holds the character right-aligned, with the unused upper bits at 0.
- R3: The enable tick on which the idle line is first seen low counts as tick 0 of a start bit. If the line is high on tick 8 after it, the character is abandoned and nothing is stored. Otherwise each later bit is sampled 16 ticks after the one before.
- R4: par_mode selects parity: 0 none, 1 even (the data bits plus the parity bit hold an even number of ones), 2 odd, 3 forced (the parity bit must equal par_force). rd_pe is 1 when the received parity bit differs from the expected one, and it is always 0 with parity off.
- R5: If the stop bit is sampled low and the data or parity bits hold any 1, the character is stored with rd_fe = 1 and rd_brk = 0.
- R6: After a framing error, if the line is low 8 ticks after the stop sample, that tick is treated as tick 0 of a new start bit, and a character that follows directly is received intact.
- R7: If the data bits, the parity bit (when enabled) and the stop bit are all 0, exactly one entry is stored, with rd_brk = 1, rd_data = 0, rd_fe = 0 and rd_pe = 0. No new start is accepted until the line has been seen high.
- R8: Entries are read in arrival order. rx_ready is 1 whenever at least one entry is held, and fifo_full is 1 when three are held.
- R9: A character that completes while three entries are held and no pop is given is discarded, and overrun becomes 1. overrun stays 1 until err_clr is asserted.
- R10: A pop with the FIFO empty has no effect. While the FIFO is empty the read outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| bits_sel | input | 2 | Character length select (5 + value bits) |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 forced |
| par_force | input | 1 | Parity bit level expected in forced mode |
| pop | input | 1 | Remove the oldest entry |
| err_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Oldest character, right-aligned |
| rd_brk | output | 1 | Oldest entry is a break |
| rd_fe | output | 1 | Oldest entry has a framing error |
| rd_pe | output | 1 | Oldest entry has a parity error |
| rx_ready | output | 1 | FIFO holds at least one entry |
| fifo_full | output | 1 | FIFO holds three entries |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions assume that tick16 is a single-cycle pulse. They also assume that bits_sel, par_mode and par_force change only while the line is idle, so the format is constant for each character. The stimulus drives every tick as a one-cycle pulse separated by idle cycles. It changes rxd and the format only between ticks, and only while the line is idle. Pop and err_clr are asserted only in cycles without a tick, so no character completes in the same cycle as a pop.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DW = 8;

  typedef enum logic [1:0] {PM_NONE = 2'd0, PM_EVEN = 2'd1, PM_ODD = 2'd2, PM_FORCE = 2'd3} srx_par_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_FEWAIT, S_BRKWAIT
  } srx_st_t;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [SRX_DW-1:0] data;
  } srx_ent_t;

  // Right-align the last (5+sel) bits shifted in from the top.
  function automatic logic [SRX_DW-1:0] srx_align(input logic [SRX_DW-1:0] sh,
                                                  input logic [1:0] sel);
    return sh >> (2'd3 - sel);
  endfunction

  // Parity bit the sender is expected to place after the data.
  function automatic logic srx_par_exp(input logic [SRX_DW-1:0] d,
                                       input srx_par_t mode, input logic fv);
    case (mode)
      PM_EVEN:  return ^d;
      PM_ODD:   return ~^d;
      PM_FORCE: return fv;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick16,
  input  logic      rxd,
  input  logic [1:0] bits_sel,
  input  srx_par_t  par_mode,
  input  logic      par_force,
  output logic      chr_done,
  output srx_ent_t  chr_ent
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] C_HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_FULL = CW'(OSR - 1);

  srx_st_t           state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bidx;
  logic [SRX_DW-1:0] sh;
  logic              parbit;

  logic [2:0]        last_idx;
  logic              par_on;
  logic              stop_tick;
  logic [SRX_DW-1:0] data_al;
  logic              all_zero;

  assign last_idx  = 3'(bits_sel) + 3'd4;
  assign par_on    = (par_mode != PM_NONE);
  assign stop_tick = tick16 && (state == S_STOP) && (cnt == C_FULL);
  assign data_al   = srx_align(sh, bits_sel);
  assign all_zero  = (data_al == '0) && !(par_on && parbit);

  assign chr_done     = stop_tick;
  assign chr_ent.data = data_al;
  assign chr_ent.brk  = !rxd && all_zero;
  assign chr_ent.fe   = !rxd && !all_zero;
  assign chr_ent.pe   = par_on && !(!rxd && all_zero) &&
                        (parbit != srx_par_exp(data_al, par_mode, par_force));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      parbit <= 1'b0;
    end else if (tick16) begin
      case (state)
        S_IDLE: if (!rxd) begin
          state <= S_START;
          cnt   <= '0;
        end
        S_START: if (cnt == C_HALF) begin
          cnt   <= '0;
          bidx  <= '0;
          state <= rxd ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == C_FULL) begin
          cnt <= '0;
          sh  <= {rxd, sh[SRX_DW-1:1]};
          if (bidx == last_idx) state <= par_on ? S_PAR : S_STOP;
          else                  bidx  <= bidx + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (cnt == C_FULL) begin
          cnt    <= '0;
          parbit <= rxd;
          state  <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == C_FULL) begin
          cnt <= '0;
          if (rxd)           state <= S_IDLE;
          else if (all_zero) state <= S_BRKWAIT;
          else               state <= S_FEWAIT;
        end else cnt <= cnt + 1'b1;
        S_FEWAIT: if (cnt == C_HALF) begin
          cnt   <= '0;
          state <= rxd ? S_IDLE : S_START;
        end else cnt <= cnt + 1'b1;
        S_BRKWAIT: if (rxd) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import srx_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  srx_ent_t ent_in,
  input  logic     pop,
  input  logic     err_clr,
  output srx_ent_t head,
  output logic     ready,
  output logic     full,
  output logic     overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] P_LAST = PW'(DEPTH - 1);
  localparam logic [NW-1:0] N_FULL = NW'(DEPTH);

  srx_ent_t      mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [NW-1:0] cnt;
  logic          do_pop, do_push;

  assign do_pop  = pop && (cnt != '0);
  assign do_push = push && ((cnt != N_FULL) || do_pop);
  assign ready   = (cnt != '0);
  assign full    = (cnt == N_FULL);
  assign head    = ready ? mem[rp] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= ent_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == P_LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == P_LAST) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (push && !do_push) overrun <= 1'b1;
      else if (err_clr)     overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] bits_sel,
  input  logic [1:0] par_mode,
  input  logic       par_force,
  input  logic       pop,
  input  logic       err_clr,
  output logic [7:0] rd_data,
  output logic       rd_brk,
  output logic       rd_fe,
  output logic       rd_pe,
  output logic       rx_ready,
  output logic       fifo_full,
  output logic       overrun
);
  logic     chr_done;
  srx_ent_t chr_ent;
  srx_ent_t head;

  srx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .bits_sel(bits_sel), .par_mode(srx_par_t'(par_mode)), .par_force(par_force),
    .chr_done(chr_done), .chr_ent(chr_ent)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(chr_done), .ent_in(chr_ent),
    .pop(pop), .err_clr(err_clr), .head(head),
    .ready(rx_ready), .full(fifo_full), .overrun(overrun)
  );

  assign rd_data = head.data;
  assign rd_brk  = head.brk;
  assign rd_fe   = head.fe;
  assign rd_pe   = head.pe;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk
  import srx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       pop,
  input logic       err_clr,
  input logic       chr_done,
  input srx_ent_t   chr_ent,
  input logic [7:0] rd_data,
  input logic       rd_brk,
  input logic       rd_fe,
  input logic       rd_pe,
  input logic       rx_ready,
  input logic       fifo_full,
  input logic       overrun
);
  p_done_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |-> tick16);

  p_brk_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done && chr_ent.brk |-> chr_ent.data == '0 && !chr_ent.fe && !chr_ent.pe);

  p_full_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rx_ready);

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full && !pop |=> fifo_full);

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done && fifo_full && !pop |=> overrun);

  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !err_clr |=> overrun);

  p_overrun_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !chr_done |=> !overrun);

  p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> rd_data == '0 && !rd_brk && !rd_fe && !rd_pe);
endmodule

bind serial_rx_fifo serial_rx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .pop(pop), .err_clr(err_clr),
  .chr_done(chr_done), .chr_ent(chr_ent), .rd_data(rd_data), .rd_brk(rd_brk),
  .rd_fe(rd_fe), .rd_pe(rd_pe), .rx_ready(rx_ready), .fifo_full(fifo_full),
  .overrun(overrun)
);

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 4;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic rxd = 1'b1;
  logic [1:0] bits_sel = 2'd3;
  logic [1:0] par_mode = 2'd0;
  logic par_force = 1'b0;
  logic pop = 1'b0;
  logic err_clr = 1'b0;
  logic [7:0] rd_data;
  logic rd_brk, rd_fe, rd_pe, rx_ready, fifo_full, overrun;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [10:0] exp_q[$];   // {brk, fe, pe, data}

  serial_rx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .bits_sel(bits_sel),
    .par_mode(par_mode), .par_force(par_force), .pop(pop), .err_clr(err_clr),
    .rd_data(rd_data), .rd_brk(rd_brk), .rd_fe(rd_fe), .rd_pe(rd_pe),
    .rx_ready(rx_ready), .fifo_full(fifo_full), .overrun(overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] sel);
    return 5 + int'(sel);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] sel,
                                   input logic [1:0] mode, input logic fv);
    int ones = 0;
    for (int i = 0; i < nbits(sel); i++) ones += int'(d[i]);
    if (mode == 2'd1) return (ones % 2) == 1;
    if (mode == 2'd2) return (ones % 2) == 0;
    return fv;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
      repeat (TICK_GAP - 1) @(negedge clk);
    end
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    ticks(16);
  endtask

  // Drive one character in the current format and record what must be stored.
  task automatic send_char(input logic [7:0] d, input bit flip, input logic stopv);
    logic [7:0] dm;
    logic pb;
    logic [10:0] e;
    bit zero;
    dm = d & 8'((1 << nbits(bits_sel)) - 1);
    pb = par_bit(dm, bits_sel, par_mode, par_force) ^ flip;
    send_bit(1'b0);
    for (int i = 0; i < nbits(bits_sel); i++) send_bit(dm[i]);
    if (par_mode != 2'd0) send_bit(pb);
    zero = (dm == 8'h00) && (par_mode == 2'd0 || pb == 1'b0);
    if (!stopv && zero)  e = {3'b100, 8'h00};
    else                 e = {1'b0, !stopv, (par_mode != 2'd0) && flip, dm};
    if (exp_q.size() < 3) exp_q.push_back(e);
    send_bit(stopv);
  endtask

  task automatic pop_check(input string req);
    logic [10:0] e;
    check(rx_ready == 1'b1, req, {31'b0, rx_ready}, 32'd1);
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      check({rd_brk, rd_fe, rd_pe, rd_data} == e, req,
            {21'b0, rd_brk, rd_fe, rd_pe, rd_data}, {21'b0, e});
    end
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1 reset state
    check({rx_ready, fifo_full, overrun} == 3'b000, "R1 status", {29'b0, rx_ready, fifo_full, overrun}, 0);
    check({rd_brk, rd_fe, rd_pe, rd_data} == 11'h0, "R1 read", {21'b0, rd_brk, rd_fe, rd_pe, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_bit(1'b1);

    // R10 pop on empty has no effect
    pop = 1'b1; @(negedge clk); pop = 1'b0; @(negedge clk);
    check(!rx_ready && rd_data == 8'h0, "R10 empty pop", {23'b0, rx_ready, rd_data}, 0);

    // R2 each length, no parity
    for (int s = 0; s < 4; s++) begin
      bits_sel = 2'(s);
      send_char(8'hB5 ^ 8'(s), 1'b0, 1'b1);
      send_bit(1'b1);
      pop_check("R2 length");
    end
    check(!rx_ready, "R10 empty after pops", {31'b0, rx_ready}, 0);

    // R4 parity modes, good and flipped
    for (int m = 1; m < 4; m++) begin
      par_mode = 2'(m);
      par_force = (m == 3);
      send_char(8'h6D, 1'b0, 1'b1); send_bit(1'b1);
      pop_check("R4 parity ok");
      send_char(8'h6D, 1'b1, 1'b1); send_bit(1'b1);
      pop_check("R4 parity err");
    end
    par_mode = 2'd0;

    // R3 short glitch is ignored
    rxd = 1'b0; ticks(5); rxd = 1'b1; ticks(40);
    check(!rx_ready, "R3 glitch", {31'b0, rx_ready}, 0);

    // R5 framing error, line returns high
    send_char(8'h5A, 1'b0, 1'b0); send_bit(1'b1);
    pop_check("R5 framing");
    check(!rx_ready, "R5 single entry", {31'b0, rx_ready}, 0);

    // R6 framing error followed at once by a new character
    send_char(8'h33, 1'b0, 1'b0);
    send_char(8'h4C, 1'b0, 1'b1);
    send_bit(1'b1);
    pop_check("R6 fe char");
    pop_check("R6 resync char");

    // R7 break with a long low line
    par_mode = 2'd1;
    send_char(8'h00, 1'b0, 1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1);
    pop_check("R7 break");
    check(!rx_ready, "R7 one break entry", {31'b0, rx_ready}, 0);
    send_char(8'hC3, 1'b0, 1'b1); send_bit(1'b1);
    pop_check("R7 after break");
    par_mode = 2'd0;

    // R8/R9 fill and overrun
    for (int k = 0; k < 4; k++) begin
      send_char(8'h10 + 8'(k), 1'b0, 1'b1);
      send_bit(1'b1);
    end
    check(fifo_full && rx_ready, "R8 full", {30'b0, fifo_full, rx_ready}, 3);
    check(overrun, "R9 overrun set", {31'b0, overrun}, 1);
    pop_check("R8 order 0");
    pop_check("R8 order 1");
    pop_check("R8 order 2");
    check(!rx_ready && overrun, "R9 overrun sticky", {30'b0, rx_ready, overrun}, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
    check(!overrun, "R9 overrun cleared", {31'b0, overrun}, 0);

    // Random formats and characters (R2, R4, R5, R7)
    for (int r = 0; r < 30; r++) begin
      bits_sel  = 2'($urandom_range(0, 3));
      par_mode  = 2'($urandom_range(0, 3));
      par_force = 1'($urandom_range(0, 1));
      send_char(8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) != 0));
      send_bit(1'b1);
      pop_check("R2 R4 R5 R7 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule